// File: doc/BRIEF.md
# Comparator Edge Event Register Bank

This block sits behind four comparator channels and turns the already filtered output of each one into software-visible events. A one-cycle-delayed copy of each output is kept, so a low-to-high change and a high-to-low change are each seen as a single-cycle pulse. Each pulse sets its own sticky flag, and that flag stays set until software clears it.

Each flag is masked by two separate enable pairs. The interrupt enables drive one interrupt line per channel. The DMA enables drive one DMA request line per channel. A plain 32-bit register port holds each channel's configuration word and its 8-bit reference level. Both of these are also driven out to the analog and filter logic. The same port exposes the status flags and both enable pairs. Reads are combinational and writes take effect at the clock edge.

Top module: `cmp_evt_bank`

## Requirements
- R1: Each channel owns a 32-byte window at byte address channel*0x20. Inside the window, the configuration word is at offset 0x00, the reference level at 0x04, status at 0x10, interrupt enable at 0x14 and DMA enable at 0x18. Read data reflects `reg_addr_i` in the same cycle.
- R2: The configuration word stores all 32 written bits and drives them on that channel's slice of `cfg_o`, starting in the cycle after the write. The reference level stores bits 7:0 only, reads bits 31:8 as zero, and drives the channel's slice of `level_o`.
- R3: Status bit 0 (rising flag) becomes 1 in the cycle after `cmp_i[c]` is first sampled high following a sampled low.
- R4: Status bit 1 (falling flag) becomes 1 in the cycle after `cmp_i[c]` is first sampled low following a sampled high.
- R5: Writing 1 to a status bit clears that flag. Writing 0 to a status bit leaves it unchanged. Each flag otherwise holds its value.
- R6: If a new edge and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R7: `irq_o[c]` is 1 when the rising flag is set and interrupt-enable bit 0 is set, or when the falling flag is set and interrupt-enable bit 1 is set.
- R8: `dma_o[c]` follows the same rule as R7, using DMA-enable bits 0 (rising) and 1 (falling).
- R9: Offsets 0x08, 0x0C and 0x1C, and any offset that is not word-aligned, read as zero and ignore writes. Bits 31:2 of status and of both enable registers read as zero.
- R10: After reset, all stored registers and flags are zero, both request lines are low, and each delayed copy of `cmp_i` is 0.
- R11: A write to one channel's window changes no register in any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | NCH | Filtered comparator output, one bit per channel |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW (7) | Byte address |
| reg_wdata_i | input | DW (32) | Write data |
| reg_rdata_o | output | DW (32) | Combinational read data |
| cfg_o | output | NCH*DW | Configuration word of each channel, channel 0 in the low bits |
| level_o | output | NCH*LVL_W | Reference level of each channel, channel 0 in the low bits |
| irq_o | output | NCH | Interrupt request per channel |
| dma_o | output | NCH | DMA request per channel |

## Verification
The bench goes after the priority case in which a new edge arrives in the same cycle as a write-1 clear. A design that lets the clear win would drop the event, and the status would read 0 where 1 is expected. It checks the flag timing on both sides of the edge-sampling clock, so a design that flags one cycle early or late shows up in the read value. Masking is tested against the wrong edge type: a swapped enable bit raises an interrupt or DMA request on the wrong flag. Writes are also sent to reserved offsets and to a neighbouring channel, to catch a decoder that aliases offsets or channels.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
  localparam int unsigned GRP_AW = 5;  // 32-byte window per channel
  localparam logic [GRP_AW-1:0] OFF_CFG = 5'h00;
  localparam logic [GRP_AW-1:0] OFF_LVL = 5'h04;
  localparam logic [GRP_AW-1:0] OFF_STS = 5'h10;
  localparam logic [GRP_AW-1:0] OFF_IEN = 5'h14;
  localparam logic [GRP_AW-1:0] OFF_DEN = 5'h18;

  typedef struct packed {
    logic fall;
    logic rise;
  } evt_pair_t;
endpackage

// File: rtl/cmp_evt_edge.sv
module cmp_evt_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_d_q <= 1'b0;
    else         lvl_d_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_d_q;
  assign fall_o = ~lvl_i & lvl_d_q;
endmodule

// File: rtl/cmp_evt_chan.sv
module cmp_evt_chan
  import cmp_evt_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned LVL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [GRP_AW-1:0] off_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic [DW-1:0]     cfg_o,
  output logic [LVL_W-1:0]  lvl_o,
  output evt_pair_t         flags_o,
  output logic              irq_o,
  output logic              dma_o,
  output logic [DW-1:0]     rdata_o
);
  logic [DW-1:0]    cfg_q;
  logic [LVL_W-1:0] lvl_q;
  evt_pair_t        flg_q, ien_q, den_q;
  logic             sts_wr;

  assign sts_wr = wr_i && (off_i == OFF_STS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      lvl_q <= '0;
      flg_q <= '0;
      ien_q <= '0;
      den_q <= '0;
    end else begin
      if (wr_i && off_i == OFF_CFG) cfg_q <= wdata_i;
      if (wr_i && off_i == OFF_LVL) lvl_q <= wdata_i[LVL_W-1:0];
      if (wr_i && off_i == OFF_IEN) ien_q <= wdata_i[1:0];
      if (wr_i && off_i == OFF_DEN) den_q <= wdata_i[1:0];
      // hardware set has priority over write-1 clear
      flg_q.rise <= (flg_q.rise & ~(sts_wr & wdata_i[0])) | rise_i;
      flg_q.fall <= (flg_q.fall & ~(sts_wr & wdata_i[1])) | fall_i;
    end
  end

  always_comb begin
    unique case (off_i)
      OFF_CFG: rdata_o = cfg_q;
      OFF_LVL: rdata_o = DW'(lvl_q);
      OFF_STS: rdata_o = DW'(flg_q);
      OFF_IEN: rdata_o = DW'(ien_q);
      OFF_DEN: rdata_o = DW'(den_q);
      default: rdata_o = '0;
    endcase
  end

  assign cfg_o   = cfg_q;
  assign lvl_o   = lvl_q;
  assign flags_o = flg_q;
  assign irq_o   = |(flg_q & ien_q);
  assign dma_o   = |(flg_q & den_q);
endmodule

// File: rtl/cmp_evt_rdmux.sv
module cmp_evt_rdmux #(
  parameter int unsigned NCH  = 4,
  parameter int unsigned DW   = 32,
  parameter int unsigned CHW  = 2
) (
  input  logic [CHW-1:0]    sel_i,
  input  logic [NCH*DW-1:0] data_i,
  output logic [DW-1:0]     data_o
);
  always_comb begin
    data_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (sel_i == CHW'(c)) data_o = data_i[c*DW +: DW];
    end
  end
endmodule

// File: rtl/cmp_evt_bank.sv
module cmp_evt_bank
  import cmp_evt_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  parameter int unsigned DW    = 32,
  parameter int unsigned LVL_W = 8,
  localparam int unsigned CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned AW   = GRP_AW + CHW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NCH-1:0]       cmp_i,
  input  logic                 reg_we_i,
  input  logic [AW-1:0]        reg_addr_i,
  input  logic [DW-1:0]        reg_wdata_i,
  output logic [DW-1:0]        reg_rdata_o,
  output logic [NCH*DW-1:0]    cfg_o,
  output logic [NCH*LVL_W-1:0] level_o,
  output logic [NCH-1:0]       irq_o,
  output logic [NCH-1:0]       dma_o
);
  logic [CHW-1:0]    ch_idx;
  logic [GRP_AW-1:0] off;
  logic [NCH*DW-1:0] ch_rdata;
  logic [NCH-1:0]    flag_rise, flag_fall;

  assign ch_idx = reg_addr_i[AW-1:GRP_AW];
  assign off    = reg_addr_i[GRP_AW-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic      rise, fall;
    evt_pair_t flags;

    cmp_evt_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (cmp_i[c]),
      .rise_o (rise),
      .fall_o (fall)
    );

    cmp_evt_chan #(.DW(DW), .LVL_W(LVL_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (reg_we_i && (ch_idx == CHW'(c))),
      .off_i   (off),
      .wdata_i (reg_wdata_i),
      .rise_i  (rise),
      .fall_i  (fall),
      .cfg_o   (cfg_o[c*DW +: DW]),
      .lvl_o   (level_o[c*LVL_W +: LVL_W]),
      .flags_o (flags),
      .irq_o   (irq_o[c]),
      .dma_o   (dma_o[c]),
      .rdata_o (ch_rdata[c*DW +: DW])
    );

    assign flag_rise[c] = flags.rise;
    assign flag_fall[c] = flags.fall;
  end

  cmp_evt_rdmux #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_rdmux (
    .sel_i  (ch_idx),
    .data_i (ch_rdata),
    .data_o (reg_rdata_o)
  );
endmodule

// File: rtl/cmp_evt_bank_chk.sv
module cmp_evt_bank_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 7,
  parameter int unsigned DW  = 32
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] cmp_i,
  input logic           reg_we_i,
  input logic [AW-1:0]  reg_addr_i,
  input logic [DW-1:0]  reg_wdata_i,
  input logic [NCH-1:0] irq_o,
  input logic [NCH-1:0] dma_o,
  input logic [NCH-1:0] rise_q,
  input logic [NCH-1:0] fall_q
);
  for (genvar c = 0; c < NCH; c++) begin : g_c
    logic sts_hit;
    assign sts_hit = reg_we_i && (reg_addr_i == AW'(c*32 + 16));

    // R3
    rise_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cmp_i[c]) |=> rise_q[c]);
    // R4
    fall_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cmp_i[c]) |=> fall_q[c]);
    // R5
    rise_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_q[c] && !(sts_hit && reg_wdata_i[0]) |=> rise_q[c]);
    // R5
    fall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_q[c] && !(sts_hit && reg_wdata_i[1]) |=> fall_q[c]);
    // R3
    rise_spur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rise_q[c] && !$rose(cmp_i[c]) |=> !rise_q[c]);
    // R7
    irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> (rise_q[c] || fall_q[c]));
    // R8
    dma_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dma_o[c] |-> (rise_q[c] || fall_q[c]));
  end
endmodule

bind cmp_evt_bank cmp_evt_bank_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmp_i       (cmp_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .dma_o       (dma_o),
  .rise_q      (flag_rise),
  .fall_q      (flag_fall)
);

// File: tb/tb_cmp_evt_bank.sv
module tb_cmp_evt_bank;
  localparam int NCH = 4;
  localparam int DW  = 32;
  localparam int LW  = 8;
  localparam int AW  = 7;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NCH-1:0]    cmp = '0;
  logic              we = 1'b0;
  logic [AW-1:0]     addr = '0;
  logic [DW-1:0]     wdata = '0;
  logic [DW-1:0]     rdata;
  logic [NCH*DW-1:0] cfg;
  logic [NCH*LW-1:0] lvl;
  logic [NCH-1:0]    irq, dma;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  cmp_evt_bank dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmp_i(cmp), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cfg_o(cfg), .level_o(lvl), .irq_o(irq), .dma_o(dma)
  );

  function automatic logic [AW-1:0] a(int ch, int off);
    return AW'(ch*32 + off);
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(int ch, int off, logic [DW-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a(ch, off); wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd_chk(string req, int ch, int off, logic [DW-1:0] exp);
    @(negedge clk);
    addr = a(ch, off); #1;
    check(req, rdata, exp);
  endtask

  task automatic t_reset();
    for (int c = 0; c < NCH; c++) rd_chk("R10 status", c, 16, 0);
    check("R10 irq/dma", {28'b0, irq | dma}, 0);
    check("R10 cfg", cfg[DW-1:0] | cfg[DW*NCH-1 -: DW], 0);
  endtask

  task automatic t_cfg();
    wr(1, 0, 32'hA5C3_1234);
    rd_chk("R2 cfg read", 1, 0, 32'hA5C3_1234);
    check("R2 cfg_o", cfg[1*DW +: DW], 32'hA5C3_1234);
    wr(2, 4, 32'hFFFF_FF7E);
    rd_chk("R2 level read", 2, 4, 32'h7E);
    check("R2 level_o", 32'(lvl[2*LW +: LW]), 32'h7E);
    wr(0, 20, 32'hFFFF_FFFF);
    rd_chk("R9 ien upper bits", 0, 20, 32'h3);
    wr(0, 20, 0);
  endtask

  task automatic t_reserved();
    wr(0, 8,  32'hFFFF_FFFF);
    wr(0, 12, 32'hFFFF_FFFF);
    wr(0, 28, 32'hFFFF_FFFF);
    wr(0, 2,  32'hFFFF_FFFF);
    rd_chk("R9 rsvd 08", 0, 8, 0);
    rd_chk("R9 rsvd 1C", 0, 28, 0);
    rd_chk("R9 cfg untouched", 0, 0, 0);
    rd_chk("R9 lvl untouched", 0, 4, 0);
  endtask

  task automatic t_rise();
    @(negedge clk);
    cmp[0] = 1'b1; addr = a(0, 16); #1;
    check("R3 not yet set", rdata, 0);
    rd_chk("R3 rise flag", 0, 16, 32'h1);
  endtask

  task automatic t_fall();
    @(negedge clk); cmp[0] = 1'b0;
    rd_chk("R4 fall flag", 0, 16, 32'h3);
  endtask

  task automatic t_w1c();
    wr(0, 16, 0);
    rd_chk("R5 write 0 keeps", 0, 16, 32'h3);
    wr(0, 16, 32'h1);
    rd_chk("R5 clear rise", 0, 16, 32'h2);
    wr(0, 16, 32'h2);
    rd_chk("R5 clear fall", 0, 16, 32'h0);
  endtask

  task automatic t_set_wins();
    @(negedge clk); cmp[0] = 1'b1;
    @(negedge clk); cmp[0] = 1'b0;
    rd_chk("R6 setup", 0, 16, 32'h3);
    @(negedge clk);
    cmp[0] = 1'b1; we = 1'b1; addr = a(0, 16); wdata = 32'h3;
    @(posedge clk); #1; we = 1'b0;
    rd_chk("R6 set wins", 0, 16, 32'h1);
  endtask

  task automatic t_irq();
    // rise flag of ch0 is set here
    @(negedge clk); #1;
    check("R7 ien=0", 32'(irq[0]), 0);
    wr(0, 20, 32'h2);
    @(negedge clk); #1;
    check("R7 wrong mask", 32'(irq[0]), 0);
    wr(0, 20, 32'h1);
    @(negedge clk); #1;
    check("R7 rise irq", 32'(irq), 32'h1);
    check("R8 no dma", 32'(dma), 0);
    wr(0, 16, 32'h1);
    @(negedge clk); #1;
    check("R7 cleared", 32'(irq), 0);
    @(negedge clk); cmp[0] = 1'b0;
    wr(0, 20, 32'h2);
    @(negedge clk); #1;
    check("R7 fall irq", 32'(irq), 32'h1);
  endtask

  task automatic t_dma();
    // fall flag of ch0 is set, rise clear
    wr(0, 24, 32'h1);
    @(negedge clk); #1;
    check("R8 wrong mask", 32'(dma), 0);
    wr(0, 24, 32'h2);
    @(negedge clk); #1;
    check("R8 fall dma", 32'(dma), 32'h1);
    wr(0, 16, 32'h2);
    @(negedge clk); #1;
    check("R8 cleared", 32'(dma | irq), 0);
  endtask

  task automatic t_indep();
    @(negedge clk); cmp[3] = 1'b1;
    rd_chk("R11 ch3 rise", 3, 16, 32'h1);
    rd_chk("R11 ch2 quiet", 2, 16, 0);
    wr(2, 16, 32'h3);
    wr(2, 0, 32'hDEAD_BEEF);
    rd_chk("R11 ch3 kept", 3, 16, 32'h1);
    rd_chk("R11 ch1 cfg kept", 1, 0, 32'hA5C3_1234);
    rd_chk("R1 ch2 cfg", 2, 0, 32'hDEAD_BEEF);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    t_reset();
    t_cfg();
    t_reserved();
    t_rise();
    t_fall();
    t_w1c();
    t_set_wins();
    t_irq();
    t_dma();
    t_indep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule